// File: doc/BRIEF.md
# Dual-Mode Processor Bus Register Bridge

This block connects an external asynchronous processor bus to an internal bank of 16-bit storage registers. A two-bit mode input picks one of two strobe conventions. The first uses separate active-low read and write strobes. The second uses one active-low data strobe, with a read/not-write level that gives the direction. A width input selects a data bus that is 8 or 16 bits wide. Byte and word accesses may be freely mixed. A byte-select pin and address bit 0 choose the byte lanes. The lane order is reversed between the two conventions.

All strobes and the address-latch line are resynchronised to the internal clock through two flops. Each access is acted on once, when its strobe is seen to assert. In the separate-strobe convention, a toggling address-latch line switches the bridge to a shared address/data bus: the address is taken from the low data pins when the latch line falls. A latch line held at a constant level leaves the dedicated address pins in use. The block does not drive a tri-state bus. It presents read data on an output vector and asserts a separate output-enable.

Top module: `pbus_bridge`

## Requirements
- R1: `mode_sel` 2'b00 selects the separate-strobe convention (`rd_n`/`wr_n`) and 2'b01 selects the data-strobe convention (`ds_n` with `rw`, where 1 means read). Codes 2'b10 and 2'b11 are reserved: in those modes no write changes any register and `dat_oe` stays low.
- R2: With `wide_bus`=0, only `dat_in[7:0]` carries data. Address bit 0 = 0 selects the low byte of the register at address bits [ADDR_W-1:1], and bit 0 = 1 selects its high byte. `bsel_n` is ignored, and on a read `dat_out[15:8]` is 0.
- R3: Separate-strobe convention, 16-bit bus, lanes chosen by (`bsel_n`, A0). (0,0) is a word access with register bits [15:0] on D[15:0]. (0,1) moves the high register byte on D[15:8]. (1,0) moves the low register byte on D[7:0].
- R4: Data-strobe convention, 16-bit bus, lanes chosen by (`bsel_n`, A0). (0,0) is a word access with the low register byte on D[15:8] and the high register byte on D[7:0]. (0,1) moves the high register byte on D[7:0]. (1,0) moves the low register byte on D[15:8].
- R5: On a 16-bit bus, (`bsel_n`, A0) = (1,1) performs no transfer: a write changes nothing and a read leaves `dat_oe` low.
- R6: A write updates only the byte lanes it selects. The other byte of the register keeps its value.
- R7: A write is committed exactly once, a few clocks after its strobe asserts. Holding the strobe low does not repeat it.
- R8: `dat_oe` is high only while a read strobe is asserted and the access is a valid transfer. Unselected lanes of `dat_out` are 0, and `dat_oe` is low once the strobe is released.
- R9: In the separate-strobe convention, once `ale` has toggled, the address is captured from `dat_in[ADDR_W-1:0]` when `ale` falls. This address is held until the next fall, and `addr_in` is not used.
- R10: The data-strobe convention always takes the address from `addr_in`. Toggling `ale` in that convention has no effect, and a change to that mode clears the shared-bus state.
- R11: After reset every register reads 0 and `dat_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Strobe convention select |
| wide_bus | input | 1 | 1 = 16-bit data bus, 0 = 8-bit |
| ale | input | 1 | Address-latch line |
| addr_in | input | ADDR_W | Dedicated byte-address pins |
| dat_in | input | 16 | Data in (address in shared-bus phase) |
| rd_n | input | 1 | Read strobe, separate-strobe convention |
| wr_n | input | 1 | Write strobe, separate-strobe convention |
| ds_n | input | 1 | Data strobe, data-strobe convention |
| rw | input | 1 | Direction for the data strobe, 1 = read |
| bsel_n | input | 1 | Byte-select, active low |
| dat_out | output | 16 | Read data |
| dat_oe | output | 1 | Read-data output enable |

## Verification
The bench builds the bridge with ADDR_W=6, which gives 32 registers. The top address bit therefore takes part in both the dedicated-pin decode and the captured shared-bus address, so an address that is captured or routed wrongly lands in a distinguishable register. Random mixes of widths, lanes and directions run in each convention against a shadow model. In the shared-bus phase the dedicated pins carry a wrong address, and in the data-strobe phase the data pins carry a wrong address during latch pulses, so a wrong address source shows up at read-back.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    typedef enum logic [1:0] {
        BUS_SPLIT = 2'b00,
        BUS_DSTRB = 2'b01,
        BUS_RSV_A = 2'b10,
        BUS_RSV_B = 2'b11
    } bus_mode_e;

    typedef struct packed {
        logic valid;
        logic en_lo;
        logic en_hi;
        logic swap;
        logic narrow;
    } lane_sel_t;

    localparam int SYNC_STAGES = 2;
    localparam int DATA_W      = 16;

    function automatic lane_sel_t decode_lanes(input logic [1:0] mode, input logic wide,
                                               input logic bsel_n, input logic a0);
        lane_sel_t l;
        l = '0;
        if (mode == BUS_SPLIT || mode == BUS_DSTRB) begin
            if (!wide) begin
                l.narrow = 1'b1;
                l.en_lo  = !a0;
                l.en_hi  = a0;
            end else begin
                l.en_lo  = !a0;
                l.en_hi  = !bsel_n;
                l.swap   = (mode == BUS_DSTRB);
            end
            l.valid = l.en_lo | l.en_hi;
        end
        return l;
    endfunction

    function automatic logic [DATA_W-1:0] bus_to_reg(input lane_sel_t l, input logic [DATA_W-1:0] d);
        if (l.narrow)    return {d[7:0], d[7:0]};
        else if (l.swap) return {d[7:0], d[15:8]};
        else             return d;
    endfunction

    function automatic logic [DATA_W-1:0] reg_to_bus(input lane_sel_t l, input logic [DATA_W-1:0] w);
        logic [DATA_W-1:0] m;
        m = {l.en_hi ? w[15:8] : 8'h00, l.en_lo ? w[7:0] : 8'h00};
        if (l.narrow)    return {8'h00, m[15:8] | m[7:0]};
        else if (l.swap) return {m[7:0], m[15:8]};
        else             return m;
    endfunction

endpackage

// File: rtl/pbus_sync.sv
module pbus_sync import pbus_pkg::*; #(
    parameter int          WIDTH   = 4,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [SYNC_STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= async_in;
            for (int i = 1; i < SYNC_STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_out = stage_q[SYNC_STAGES-1];
endmodule

// File: rtl/pbus_strobe_ctl.sv
module pbus_strobe_ctl import pbus_pkg::*; #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode,
    input  logic          ale_s,
    input  logic          rd_s,
    input  logic          wr_s,
    input  logic          ds_s,
    input  logic          rw,
    input  logic [AW-1:0] mux_ad,
    input  logic [AW-1:0] pin_ad,
    output logic          wr_go,
    output logic          rd_act,
    output logic          mux_q,
    output logic [AW-1:0] eff_addr
);
    localparam int PIPE = SYNC_STAGES + 1;

    logic          ale_q, wr_q, ds_q;
    logic [AW-1:0] ad_p [PIPE];
    logic [AW-1:0] lat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ale_q <= 1'b0;
            wr_q  <= 1'b1;
            ds_q  <= 1'b1;
            mux_q <= 1'b0;
            lat_q <= '0;
            for (int i = 0; i < PIPE; i++) ad_p[i] <= '0;
        end else begin
            ale_q <= ale_s;
            wr_q  <= wr_s;
            ds_q  <= ds_s;
            ad_p[0] <= mux_ad;
            for (int i = 1; i < PIPE; i++) ad_p[i] <= ad_p[i-1];
            if (ale_q && !ale_s) lat_q <= ad_p[PIPE-1];
            if (mode != BUS_SPLIT)     mux_q <= 1'b0;
            else if (ale_q != ale_s)   mux_q <= 1'b1;
        end
    end

    always_comb begin
        wr_go  = 1'b0;
        rd_act = 1'b0;
        case (mode)
            BUS_SPLIT: begin
                wr_go  = wr_q && !wr_s;
                rd_act = !rd_s;
            end
            BUS_DSTRB: begin
                wr_go  = ds_q && !ds_s && !rw;
                rd_act = !ds_s && rw;
            end
            default: ;
        endcase
    end

    assign eff_addr = (mux_q && mode == BUS_SPLIT) ? lat_q : pin_ad;

    // R7
    wr_once_chk: assert property (@(posedge clk) disable iff (rst) wr_go |=> !wr_go);

    // R10
    dstrb_demux_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != BUS_SPLIT) |=> !mux_q);
endmodule

// File: rtl/pbus_regfile.sv
module pbus_regfile import pbus_pkg::*; #(
    parameter int AW = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        be,
    input  logic [AW-2:0]     idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int NREG = 2 ** (AW - 1);

    logic [DATA_W-1:0] mem [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (we) begin
            if (be[0]) mem[idx][7:0]  <= wdata[7:0];
            if (be[1]) mem[idx][15:8] <= wdata[15:8];
        end
    end

    assign rdata = mem[idx];

    // R6
    keep_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (we && !be[1]) |=> mem[$past(idx)][15:8] == $past(mem[idx][15:8]));

    // R6
    keep_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (we && !be[0]) |=> mem[$past(idx)][7:0] == $past(mem[idx][7:0]));
endmodule

// File: rtl/pbus_bridge.sv
module pbus_bridge import pbus_pkg::*; #(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_sel,
    input  logic              wide_bus,
    input  logic              ale,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [15:0]       dat_in,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              ds_n,
    input  logic              rw,
    input  logic              bsel_n,
    output logic [15:0]       dat_out,
    output logic              dat_oe
);
    logic [3:0]        sync_s;
    logic              wr_go, rd_act, mux_q;
    logic [ADDR_W-1:0] eff_addr;
    lane_sel_t         lane;
    logic [15:0]       word_q;

    pbus_sync #(.WIDTH(4), .RST_VAL(4'b1110)) sync_i (
        .clk      (clk),
        .rst      (rst),
        .async_in ({rd_n, wr_n, ds_n, ale}),
        .sync_out (sync_s)
    );

    pbus_strobe_ctl #(.AW(ADDR_W)) ctl_i (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode_sel),
        .ale_s    (sync_s[0]),
        .rd_s     (sync_s[3]),
        .wr_s     (sync_s[2]),
        .ds_s     (sync_s[1]),
        .rw       (rw),
        .mux_ad   (dat_in[ADDR_W-1:0]),
        .pin_ad   (addr_in),
        .wr_go    (wr_go),
        .rd_act   (rd_act),
        .mux_q    (mux_q),
        .eff_addr (eff_addr)
    );

    assign lane = decode_lanes(mode_sel, wide_bus, bsel_n, eff_addr[0]);

    pbus_regfile #(.AW(ADDR_W)) rf_i (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_go && lane.valid),
        .be    ({lane.en_hi, lane.en_lo}),
        .idx   (eff_addr[ADDR_W-1:1]),
        .wdata (bus_to_reg(lane, dat_in)),
        .rdata (word_q)
    );

    assign dat_oe  = rd_act && lane.valid;
    assign dat_out = dat_oe ? reg_to_bus(lane, word_q) : 16'h0000;

    // R1
    rsv_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        mode_sel[1] |-> !dat_oe);

    // R2
    narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
        !wide_bus |-> dat_out[15:8] == 8'h00);

    // R5
    no_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        (wide_bus && bsel_n && eff_addr[0]) |-> !dat_oe);
endmodule

// File: tb/pbus_bridge_tb.sv
module pbus_bridge_tb_top;
    localparam int AW   = 6;
    localparam int NREG = 2 ** (AW - 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode_sel = 2'b00;
    logic          wide_bus = 1'b1;
    logic          ale = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [15:0]   dat_in = '0;
    logic          rd_n = 1'b1, wr_n = 1'b1, ds_n = 1'b1, rw = 1'b1, bsel_n = 1'b1;
    logic [15:0]   dat_out;
    logic          dat_oe;

    logic [15:0]   shadow [NREG];
    int            n_chk = 0, n_fail = 0;
    bit            done = 0;

    always #4 clk = ~clk;

    pbus_bridge #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .wide_bus(wide_bus), .ale(ale),
        .addr_in(addr_in), .dat_in(dat_in), .rd_n(rd_n), .wr_n(wr_n), .ds_n(ds_n),
        .rw(rw), .bsel_n(bsel_n), .dat_out(dat_out), .dat_oe(dat_oe)
    );

    task automatic check(input bit ok, input string req, input logic [16:0] act, input logic [16:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic void lanes(input logic [1:0] m, input logic w, input logic bs,
                                  input logic a0, output logic lo, output logic hi);
        lo = 1'b0; hi = 1'b0;
        if (m == 2'b00 || m == 2'b01) begin
            lo = !a0;
            hi = w ? !bs : a0;
        end
    endfunction

    function automatic void model_write(input logic [1:0] m, input logic w, input logic bs,
                                        input logic [AW-1:0] a, input logic [15:0] d);
        logic lo, hi;
        logic [7:0] blo, bhi;
        lanes(m, w, bs, a[0], lo, hi);
        if (!w)            begin blo = d[7:0];  bhi = d[7:0];  end
        else if (m == 2'b01) begin blo = d[15:8]; bhi = d[7:0];  end
        else               begin blo = d[7:0];  bhi = d[15:8]; end
        if (lo) shadow[a[AW-1:1]][7:0]  = blo;
        if (hi) shadow[a[AW-1:1]][15:8] = bhi;
    endfunction

    function automatic logic [16:0] model_read(input logic [1:0] m, input logic w, input logic bs,
                                               input logic [AW-1:0] a);
        logic lo, hi;
        logic [15:0] wd, r;
        lanes(m, w, bs, a[0], lo, hi);
        wd = shadow[a[AW-1:1]];
        if (!w)              r = {8'h00, a[0] ? wd[15:8] : wd[7:0]};
        else if (m == 2'b01) r = {lo ? wd[7:0] : 8'h00, hi ? wd[15:8] : 8'h00};
        else                 r = {hi ? wd[15:8] : 8'h00, lo ? wd[7:0] : 8'h00};
        if (!(lo || hi)) r = 16'h0000;
        return {lo || hi, r};
    endfunction

    // Presents the address: a latch pulse with 'pulse', wrong address on the unused path.
    task automatic present_addr(input logic [AW-1:0] a, input bit pulse);
        if (pulse) begin
            if (mode_sel == 2'b00) begin
                dat_in  = {$urandom_range(1023, 0), a} ;
                addr_in = ~a;
            end else begin
                dat_in  = {10'h0, ~a};
                addr_in = a;
            end
            ale = 1'b1;
            wait_n(4);
            ale = 1'b0;
            wait_n(4);
        end else begin
            addr_in = a;
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic bs, input logic [15:0] d, input bit pulse);
        present_addr(a, pulse);
        dat_in = d; bsel_n = bs; rw = 1'b0;
        if (mode_sel == 2'b01) ds_n = 1'b0; else wr_n = 1'b0;
        wait_n(8);
        ds_n = 1'b1; wr_n = 1'b1; rw = 1'b1;
        wait_n(5);
        model_write(mode_sel, wide_bus, bs, a, d);
    endtask

    task automatic bus_read(input logic [AW-1:0] a, input logic bs, input bit pulse, input string req);
        logic [16:0] e;
        present_addr(a, pulse);
        dat_in = 16'($urandom); bsel_n = bs; rw = 1'b1;
        if (mode_sel == 2'b01) ds_n = 1'b0; else rd_n = 1'b0;
        wait_n(5);
        e = model_read(mode_sel, wide_bus, bs, a);
        check({dat_oe, dat_out} === e, req, {dat_oe, dat_out}, e);
        ds_n = 1'b1; rd_n = 1'b1;
        wait_n(5);
        check(dat_oe === 1'b0, "R8 oe after release", {16'h0, dat_oe}, 17'h0);
    endtask

    task automatic random_ops(input int n, input bit pulse, input string req);
        for (int i = 0; i < n; i++) begin
            logic [AW-1:0] a;
            a = AW'($urandom);
            wide_bus = 1'($urandom);
            if ($urandom_range(1, 0) == 1)
                bus_write(a, 1'($urandom), 16'($urandom), pulse);
            else
                bus_read(a, 1'($urandom), pulse, req);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NREG; i++) shadow[i] = 16'h0000;
        wait_n(4);
        rst = 1'b0;
        wait_n(2);
        // R11: reset state
        check(dat_oe === 1'b0, "R11 oe at reset", {16'h0, dat_oe}, 17'h0);
        wide_bus = 1'b1;
        bus_read(6'd0, 1'b0, 0, "R11 reg0 after reset");
        bus_read(6'd62, 1'b0, 0, "R11 reg31 after reset");

        // R3: directed separate-strobe lanes
        bus_write(6'd4, 1'b0, 16'hA1B2, 0);
        bus_read(6'd4, 1'b0, 0, "R3 word");
        bus_write(6'd5, 1'b0, 16'h7700, 0);
        bus_read(6'd4, 1'b0, 0, "R3 odd byte on D15:8 R6 low kept");
        bus_write(6'd4, 1'b1, 16'h0055, 0);
        bus_read(6'd4, 1'b1, 0, "R3 even byte on D7:0");
        // R5: no transfer
        bus_write(6'd5, 1'b1, 16'hFFFF, 0);
        bus_read(6'd5, 1'b1, 0, "R5 no-transfer read");
        bus_read(6'd4, 1'b0, 0, "R5 write left register unchanged");
        // R2: narrow bus
        wide_bus = 1'b0;
        bus_write(6'd9, 1'b0, 16'hEE3C, 0);
        bus_read(6'd9, 1'b1, 0, "R2 narrow high byte");
        wide_bus = 1'b1;
        bus_read(6'd8, 1'b0, 0, "R2 narrow write placed high byte R7");

        random_ops(40, 0, "R3 R11 random split demux");

        // R9: shared address/data bus
        random_ops(30, 1, "R9 random split muxed");
        // R9: address held without a new pulse
        bus_write(6'd20, 1'b0, 16'h1357, 1);
        addr_in = 6'd3;
        bus_read(6'd20, 1'b0, 0, "R9 latched address held");

        // R4 R10: data-strobe convention
        mode_sel = 2'b01;
        wait_n(4);
        wide_bus = 1'b1;
        bus_write(6'd12, 1'b0, 16'hC0DE, 0);
        bus_read(6'd12, 1'b0, 0, "R4 word swapped");
        bus_write(6'd13, 1'b0, 16'h0042, 1);
        bus_read(6'd12, 1'b0, 1, "R4 odd byte D7:0 R10 ale ignored");
        bus_read(6'd12, 1'b1, 0, "R4 even byte D15:8");
        random_ops(40, 1, "R4 R10 random data-strobe");

        // R1: reserved modes
        for (int k = 2; k < 4; k++) begin
            mode_sel = 2'(k);
            bus_write(6'd12, 1'b0, 16'hDEAD, 0);
            bus_read(6'd12, 1'b0, 0, "R1 reserved read quiet");
        end
        mode_sel = 2'b00;
        wait_n(4);
        bus_read(6'd12, 1'b0, 0, "R1 reserved write ignored R10 flag cleared");
        random_ops(20, 0, "R6 random mixed after mode change");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait_n(150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule